// File: doc/BRIEF.md
# Pointer-Addressed I2C Configuration Register Target

This block is an I2C target that gives a bus host read and write access to a small bank of 8-bit configuration registers. The host reaches the bank through an internal address pointer. The first data byte of every write transaction reloads that pointer. Later bytes in the same transaction are stored in registers. A read transaction has no pointer phase of its own. It starts at the register the pointer already selects, which is either the value left by the last write or a reset default.

The pointer byte carries a step flag in bit 7, and its low `IDX_W` bits select the register. When the flag is set, the pointer advances by one after every byte moved, in either direction, and wraps from the top register to register 0. When the flag is clear, the pointer stays where it is.

SCL and SDA are taken in as sampled levels. The block drives SDA through an open-drain enable: when `sda_oe_o` is 1 the line is pulled low. Each line passes through a two-stage synchroniser. START and STOP are recognised as SDA edges while SCL is high. The register contents are also presented in parallel, so the surrounding logic can use them.

The controller has eight states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_WR_BYTE`: shifts in a data byte.
- `ST_WR_ACK`: acknowledges a received byte.
- `ST_RD_BYTE`: shifts out a register value.
- `ST_RD_ACK`: samples the host's acknowledge.
- `ST_IGNORE`: keeps SDA released until the next START or STOP.

The transitions are:
- START goes to `ST_ADDR` from any state.
- STOP goes to `ST_IDLE` from any state.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, depending on R/W.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on an ACK, or to `ST_IGNORE` on a NACK.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0). The pointer holds `MAP_DEFAULT`, which by default is step flag 0 and register 5. Register i holds `RST_FILL | i`, which by default is 8'hA0 | i.
- R2: The address byte is acknowledged with SDA low in the ninth clock when three conditions hold: its upper six bits equal 100110, its seventh bit equals `addr_sel_i`, and its last bit is R/W (0 = write, 1 = read).
- R3: For an address byte that does not match, SDA stays released for the rest of the transaction, including the ACK slots of the following bytes, and no register changes.
- R4: In a write, the first byte after the address loads the pointer. Bit 7 becomes the step flag and bits [IDX_W-1:0] become the register index. No register is written by this byte.
- R5: With the step flag set, successive write bytes land in successive registers, wrapping from register NREG-1 to 0. Each byte is acknowledged.
- R6: With the step flag clear, every write byte lands in the same register, so the last byte wins.
- R7: A read returns the register the pointer selects, MSB first. With the step flag set, the pointer advances after each byte the host ACKs, and that advance is kept after the transaction.
- R8: With the step flag clear, a read returns the same register for every byte.
- R9: A host NACK after a read byte ends transmission. SDA is released and stays released until the next START or STOP.
- R10: A repeated START at any point restarts the address phase. A pointer written just before a repeated START selects the register for the read that follows.
- R11: The block changes SDA only while SCL is low, and `cfg_regs_o[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| addr_sel_i | input | 1 | Selects bit 1 of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs_o | output | 8*2**IDX_W | Parallel view of all registers |

## Verification
A stepping write does two things on the same clock edge: it stores the received byte at the current index, and it advances the index. A fault in their ordering puts the data one register off. The bench provokes this with bursts that cross the top register and wrap to register 0, then judges the result from the parallel register view and from later reads. In a read, the host's ACK sampling and the reload of the next outgoing byte from the advanced pointer also coincide. The bench checks that pair by comparing each received byte of a multi-byte stepping read against its own model of the bank.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/cfgi2c_busmon.sv
module cfgi2c_busmon #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // idle bus level is high; reset to it so no false START appears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  =  scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl &  scl_q;
    assign start_det =  scl_lvl & scl_q &  sda_q & ~sda_lvl;
    assign stop_det  =  scl_lvl & scl_q & ~sda_q &  sda_lvl;

endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile #(
    parameter int unsigned IDX_W    = 3,
    parameter logic [7:0]  RST_FILL = 8'hA0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  logic [7:0]                wdata,
    input  logic [IDX_W-1:0]          ridx,
    output logic [7:0]                rdata,
    output logic [(8*(2**IDX_W))-1:0] regs_flat
);

    localparam int unsigned NREG = 2 ** IDX_W;

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= RST_FILL | 8'(g);
            end else if (we && (widx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    assign rdata = regs[ridx];

    // R5/R6: a write strobe leaves its byte in the addressed entry
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import cfgi2c_pkg::*;
#(
    parameter int unsigned IDX_W       = 3,
    parameter logic [5:0]  ADDR_HI     = 6'b100110,
    parameter logic [7:0]  MAP_DEFAULT = 8'h05,
    parameter logic [7:0]  RST_FILL    = 8'hA0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic                      addr_sel_i,
    output logic                      sda_oe_o,
    output logic [(8*(2**IDX_W))-1:0] cfg_regs_o
);

    localparam logic [3:0] LAST_CNT = 4'(BITS_PER_BYTE);

    tgt_state_e       state, nxt;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic             rw_q;
    logic             first_q;
    logic             nack_q;
    logic             map_incr;
    logic [IDX_W-1:0] map_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             reg_we;
    logic             addr_hit;
    logic             byte_done;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    cfgi2c_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign addr_hit  = (rx_sh[7:2] == ADDR_HI) && (rx_sh[1] == addr_sel_i);
    assign byte_done = scl_fall && (bit_cnt == LAST_CNT);

    // register store happens when a non-pointer byte completes
    assign reg_we = (state == ST_WR_BYTE) && byte_done && !first_q
                    && !start_det && !stop_det;

    // next outgoing byte follows the pointer, stepped ahead after an ACK
    assign rd_idx = ((state == ST_RD_ACK) && map_incr) ? map_idx + IDX_W'(1) : map_idx;

    cfgi2c_regfile #(.IDX_W(IDX_W), .RST_FILL(RST_FILL)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .widx      (map_idx),
        .wdata     (rx_sh),
        .ridx      (rd_idx),
        .rdata     (rd_data),
        .regs_flat (cfg_regs_o)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  nxt = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)  nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  nxt = nack_q ? ST_IGNORE : ST_RD_BYTE;
                ST_IGNORE:   nxt = ST_IGNORE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            nack_q   <= 1'b0;
            map_incr <= MAP_DEFAULT[7];
            map_idx  <= MAP_DEFAULT[IDX_W-1:0];
        end else begin
            state <= nxt;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: begin
                        bit_cnt <= '0;
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            rw_q    <= rx_sh[0];
                            first_q <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            tx_sh   <= rd_data;
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            if (first_q) begin
                                map_incr <= rx_sh[7];
                                map_idx  <= rx_sh[IDX_W-1:0];
                                first_q  <= 1'b0;
                            end else if (map_incr) begin
                                map_idx <= map_idx + IDX_W'(1);
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall && (bit_cnt != LAST_CNT)) tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) nack_q <= sda_lvl;
                        if (scl_fall && !nack_q) begin
                            bit_cnt <= '0;
                            tx_sh   <= rd_data;
                            map_idx <= rd_idx;
                        end
                    end
                endcase
            end
        end
    end

    // output logic: open-drain pull-down enable
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD_BYTE:             sda_oe_o = ~tx_sh[7];
            ST_IDLE, ST_ADDR, ST_WR_BYTE,
            ST_RD_ACK, ST_IGNORE:   sda_oe_o = 1'b0;
        endcase
    end

    // R10: STOP always returns to idle
    a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R10: START restarts the address phase with an empty bit count
    a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> ((state == ST_ADDR) && (bit_cnt == 4'd0)));

    // R3/R9: the ignore state holds until a bus condition
    a_r3_ignore_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IGNORE) && !start_det && !stop_det) |=> (state == ST_IGNORE));

    // R8: a fixed pointer does not move during a read
    a_r8_ptr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_RD_BYTE) || (state == ST_RD_ACK)) && !map_incr && !start_det && !stop_det)
        |=> $stable(map_idx));

    // R11: SDA drive changes only with SCL low, except after a bus condition
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

endmodule

// File: tb/i2c_cfg_target_tb.sv
`timescale 1ns/1ps
module i2c_cfg_target_tb;

    localparam int IDX_W = 3;
    localparam int NREG  = 2 ** IDX_W;
    localparam int H     = 20;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic [8*NREG-1:0] regs_vec;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int r11_viol = 0;

    item_t      exp_q[$];
    logic [7:0] act_q[$];

    logic [7:0] m_regs [NREG];
    logic [IDX_W-1:0] m_idx;
    logic m_incr;

    always #2.5 clk = ~clk;

    i2c_cfg_target #(.IDX_W(IDX_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .cfg_regs_o (regs_vec)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [8*NREG-1:0] model_vec();
        logic [8*NREG-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_regs[i];
        return v;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H);
            scl_m = 1'b1; wait_n(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H/2);
        acked = ~sda_bus;
        wait_n(H/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(H);
            scl_m = 1'b1; wait_n(H/2);
            b[i] = sda_bus;
            wait_n(H/2);
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wait_n(H);
        scl_m = 1'b1; wait_n(H);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic sel, input logic rd);
        return {6'b100110, sel, rd};
    endfunction

    // write transaction: pointer byte then n data bytes, all expected to ACK
    task automatic reg_write(input string tag, input logic [7:0] map, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int n);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b0), ack);
        check({tag, " addr ack (R2)"}, ack, 1);
        send_byte(map, ack);
        check({tag, " map ack (R4)"}, ack, 1);
        m_incr = map[7];
        m_idx  = map[IDX_W-1:0];
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);
            check({tag, " data ack (R5)"}, ack, 1);
            m_regs[m_idx] = d[k];
            if (m_incr) m_idx = m_idx + 1'b1;
        end
        bus_stop();
    endtask

    // read transaction: n bytes, last one NACKed; scoreboard gets expected items
    task automatic reg_read(input string tag, input int n);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b1), ack);
        check({tag, " read addr ack (R2)"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.v = m_regs[m_idx];
            it.tag = tag;
            exp_q.push_back(it);
            recv_byte(k != n - 1, b);
            act_q.push_back(b);
            if ((k != n - 1) && m_incr) m_idx = m_idx + 1'b1;
        end
        bus_stop();
    endtask

    // monitor: compare produced bytes against expected items
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                logic [7:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check({e.tag, " read data"}, a, e.v);
            end
        end
    end

    // R11 watcher: SDA drive must not move while SCL is high
    initial begin
        logic prev_oe;
        prev_oe = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && scl_m && (sda_oe !== prev_oe)) r11_viol++;
            prev_oe = sda_oe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'hA0 | 8'(i);
        m_idx  = 3'd5;
        m_incr = 1'b0;
        wait_n(10);
        rst_n = 1'b1;
        wait_n(10);

        // R1: reset state
        check("R1 sda released", sda_oe, 0);
        check("R1 register reset values", regs_vec, model_vec());

        // R1/R8: first read uses the default pointer, which does not step
        reg_read("R1 R8 default pointer", 2);

        // R4/R5: stepping write of three bytes from register 2
        reg_write("R5 burst", 8'h82, 8'h11, 8'h22, 8'h33, 3);
        check("R5 burst register view", regs_vec, model_vec());

        // R7: stepping read continues from the advanced pointer
        reg_read("R7 stepping read", 3);

        // R4: pointer-only write changes no register
        reg_write("R4 pointer only", 8'h86, 8'h00, 8'h00, 8'h00, 0);
        check("R4 no register touched", regs_vec, model_vec());

        // R5: wrap from top register to register 0
        reg_write("R5 wrap", 8'h87, 8'h44, 8'h55, 8'h00, 2);
        check("R5 wrap register view", regs_vec, model_vec());

        // R6: fixed pointer, last byte wins
        reg_write("R6 fixed", 8'h01, 8'h66, 8'h77, 8'h00, 2);
        check("R6 fixed register view", regs_vec, model_vec());

        // R8: fixed pointer read repeats
        reg_read("R8 fixed read", 3);

        // R10: pointer write, repeated START, then read
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), ack);
        check("R10 addr ack", ack, 1);
        send_byte(8'h84, ack);
        check("R10 map ack", ack, 1);
        m_incr = 1'b1;
        m_idx  = 3'd4;
        bus_start();
        send_byte(addr_byte(1'b0, 1'b1), ack);
        check("R10 read addr ack", ack, 1);
        for (int k = 0; k < 2; k++) begin
            item_t it;
            it.v = m_regs[m_idx];
            it.tag = "R10 after repeated start";
            exp_q.push_back(it);
            recv_byte(k == 0, b);
            act_q.push_back(b);
            if (k == 0) m_idx = m_idx + 1'b1;
        end
        // R9: after the NACK the target must leave SDA released
        wait_n(H);
        check("R9 released after nack", sda_oe, 0);
        bus_stop();

        // R2/R3: select pin high, address with bit 1 clear is refused
        addr_sel = 1'b1;
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), ack);
        check("R2 R3 select mismatch nack", ack, 0);
        send_byte(8'h83, ack);
        check("R3 no ack on later byte", ack, 0);
        send_byte(8'h5A, ack);
        check("R3 no ack on data byte", ack, 0);
        bus_stop();
        check("R3 registers unchanged", regs_vec, model_vec());

        // R2: matching select bit is accepted
        reg_write("R2 select high", 8'h03, 8'h99, 8'h00, 8'h00, 1);
        check("R2 select high register view", regs_vec, model_vec());
        addr_sel = 1'b0;

        // R3: wrong upper bits
        bus_start();
        send_byte(8'h55, ack);
        check("R3 upper bits mismatch nack", ack, 0);
        bus_stop();

        // R9: single byte read NACKed, then a fresh transaction still works
        reg_read("R9 nack then new", 1);
        reg_read("R9 follow-up read", 2);

        wait_n(4 * H);
        check("R11 sda moved only with scl low", r11_viol, 0);
        check("R11 final register view", regs_vec, model_vec());
        check("scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule